// File: doc/BRIEF.md
# Channel Sequencing Averager with Peak and Trough Tracking

This block drives an external converter through a set of analog channels. It walks the channels chosen by an enable mask in ascending index order and wraps around at the end. For the channel it is on, it adds up a power-of-two number of raw 12-bit samples. It turns that sum into a 16-bit average and writes the average into the channel's recent-result slot. When statistics are enabled, it also folds the average into that channel's running maximum and running minimum.

Sequencing runs only when three conditions hold: the two sequence control bits are set, the autonomous-mode bit is set, and at least one channel is enabled. In every other case the request output stays low and incoming samples are dropped. Each finished average raises a one-cycle strobe. The strobe carries the channel number and the value, so that downstream comparators can act on it.

Top module: `chan_seq_averager`

## Requirements
- R1: After reset, every recent slot and every maximum slot reads 0x0000, every minimum slot reads 0xFFFF, and `res_valid` is 0.
- R2: `chan_req` is 1 only when all of the following hold: `seq_ctrl` bit 0 is set, `seq_ctrl` bit 4 is set, `mode_ctrl` bit 5 is set, and `chan_mask` is nonzero. While `chan_req` is 0, samples are ignored: no strobe is raised and no slot changes.
- R3: With oversampling code k on `osr_sel`, the block accepts 2^k samples. One cycle after the last of them, `res_valid` pulses for exactly one cycle. At that point `res_value` equals the sum of the samples, each shifted left by 4, then shifted right by k and truncated to 16 bits. For k = 0, this is the single sample shifted left by 4.
- R4: A finished average is written to the recent slot of its channel c in the same cycle that the strobe appears. Slot c occupies bits [16c+15:16c] of `recent_all`. `res_chan` gives c.
- R5: `chan_sel` shows the channel that is currently being converted. After a channel finishes, `chan_sel` moves to the next higher enabled channel, wrapping from 7 back to 0. Disabled channels are skipped with no idle cycle. If the channel currently pointed at becomes disabled, `chan_sel` moves at once to the next enabled channel.
- R6: While `stat_ctrl` bit 5 is 1, each finished average raises its channel's maximum slot if it is larger than the slot, and lowers its channel's minimum slot if it is smaller. While that bit is 0, the `max_all` and `min_all` outputs do not change. Slots are laid out as in R4.
- R7: An all-zero `chan_mask` holds `chan_req` at 0 and stops the sequence.
- R8: When only one channel is enabled, `chan_sel` stays on that channel from one result to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_ctrl | input | 8 | Sequence control; bit 0 is the sequence mode, bit 4 is start |
| mode_ctrl | input | 8 | Operating mode; bit 5 = 1 selects autonomous conversion |
| stat_ctrl | input | 8 | General control; bit 5 enables maximum and minimum tracking |
| osr_sel | input | 3 | Oversampling code k; the averaging ratio is 2^k |
| chan_mask | input | 8 | Bit n enables channel n in the sequence |
| smp_valid | input | 1 | Raw sample present this cycle |
| smp_data | input | 12 | Raw converter sample |
| chan_req | output | 1 | Conversion request, active while sequencing runs |
| chan_sel | output | 3 | Channel to convert |
| res_valid | output | 1 | One-cycle strobe for a finished average |
| res_chan | output | 3 | Channel of the finished average |
| res_value | output | 16 | Finished 16-bit average |
| recent_all | output | 128 | Recent result of each channel, 16 bits per channel |
| max_all | output | 128 | Running maximum of each channel |
| min_all | output | 128 | Running minimum of each channel |

## Verification
The assertions check the following on every cycle:
- A strobe only follows a sample that was accepted while requested.
- The strobe's channel matches the channel that was selected.
- Recent slots change only together with a strobe.
- The maximum and minimum slots freeze while statistics are off.
- A zero mask never requests.
- The selected channel is always an enabled one.

The arithmetic of the average for each oversampling code, the exact order of the round-robin, and the right comparison results for the maximum and minimum slots can only be shown by the bench's scenarios. The bench compares those outputs against values it computes itself.

// File: rtl/seq_avg_pkg.sv
package seq_avg_pkg;
    localparam int unsigned DEF_NCH   = 8;
    localparam int unsigned DEF_SMP_W = 12;
    localparam int unsigned DEF_RES_W = 16;
    localparam int unsigned DEF_OSR_W = 3;
    localparam int unsigned CFG_W     = 8;

    // control bit positions
    localparam int unsigned SEQ_MODE_BIT  = 0;
    localparam int unsigned SEQ_START_BIT = 4;
    localparam int unsigned AUTO_BIT      = 5;
    localparam int unsigned STATS_BIT     = 5;
endpackage

// File: rtl/seq_avg_next.sv
// First enabled channel strictly after base, wrapping; base itself at distance NCH.
module seq_avg_next #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [NCH-1:0]   mask,
    input  logic [IDX_W-1:0] base,
    output logic [IDX_W-1:0] nxt
);
    always_comb begin
        nxt = base;
        for (int d = NCH; d >= 1; d--) begin
            if (mask[(int'(base) + d) % NCH]) begin
                nxt = IDX_W'((int'(base) + d) % NCH);
            end
        end
    end
endmodule

// File: rtl/seq_avg_accum.sv
module seq_avg_accum #(
    parameter int unsigned SMP_W = 12,
    parameter int unsigned RES_W = 16,
    parameter int unsigned OSR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [SMP_W-1:0] smp,
    input  logic [OSR_W-1:0] osr,
    output logic             done,
    output logic [RES_W-1:0] avg
);
    localparam int unsigned CNT_W = (1 << OSR_W) - 1;
    localparam int unsigned ACC_W = RES_W + CNT_W;
    localparam int unsigned PAD_W = RES_W - SMP_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W-1:0] sum;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = {CNT_W{1'b1}} >> (CNT_W - int'(osr));
        sum  = st_q.acc + (ACC_W'(smp) << PAD_W);
        done = take && (st_q.cnt == last);
        avg  = RES_W'(sum >> osr);
        st_d = st_q;
        if (clr || done) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (take) begin
            st_d.acc = sum;
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/seq_avg_stats.sv
module seq_avg_stats #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned RES_W = 16,
    parameter int unsigned IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [IDX_W-1:0]     wr_ch,
    input  logic [RES_W-1:0]     wr_val,
    input  logic                 stat_en,
    output logic [NCH*RES_W-1:0] rec_all,
    output logic [NCH*RES_W-1:0] max_all,
    output logic [NCH*RES_W-1:0] min_all
);
    typedef struct packed {
        logic [RES_W-1:0] rec;
        logic [RES_W-1:0] hi;
        logic [RES_W-1:0] lo;
    } slot_t;

    localparam slot_t SLOT_RST = '{rec: '0, hi: '0, lo: '1};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        slot_t sl_d, sl_q;
        logic  hit;

        always_comb begin
            hit  = wr && (wr_ch == IDX_W'(c));
            sl_d = sl_q;
            if (hit) begin
                sl_d.rec = wr_val;
                if (stat_en && (wr_val > sl_q.hi)) sl_d.hi = wr_val;
                if (stat_en && (wr_val < sl_q.lo)) sl_d.lo = wr_val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sl_q <= SLOT_RST;
            else        sl_q <= sl_d;
        end

        assign rec_all[c*RES_W +: RES_W] = sl_q.rec;
        assign max_all[c*RES_W +: RES_W] = sl_q.hi;
        assign min_all[c*RES_W +: RES_W] = sl_q.lo;
    end
endmodule

// File: rtl/chan_seq_averager.sv
module chan_seq_averager
    import seq_avg_pkg::*;
#(
    parameter  int unsigned NCH   = DEF_NCH,
    parameter  int unsigned SMP_W = DEF_SMP_W,
    parameter  int unsigned RES_W = DEF_RES_W,
    parameter  int unsigned OSR_W = DEF_OSR_W,
    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_W-1:0]     seq_ctrl,
    input  logic [CFG_W-1:0]     mode_ctrl,
    input  logic [CFG_W-1:0]     stat_ctrl,
    input  logic [OSR_W-1:0]     osr_sel,
    input  logic [NCH-1:0]       chan_mask,
    input  logic                 smp_valid,
    input  logic [SMP_W-1:0]     smp_data,
    output logic                 chan_req,
    output logic [IDX_W-1:0]     chan_sel,
    output logic                 res_valid,
    output logic [IDX_W-1:0]     res_chan,
    output logic [RES_W-1:0]     res_value,
    output logic [NCH*RES_W-1:0] recent_all,
    output logic [NCH*RES_W-1:0] max_all,
    output logic [NCH*RES_W-1:0] min_all
);
    typedef struct packed {
        logic [IDX_W-1:0] cur;
        logic             vld;
        logic [IDX_W-1:0] ch;
        logic [RES_W-1:0] val;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             run, take, done;
    logic [IDX_W-1:0] skip_cur, eff, after_eff;
    logic [RES_W-1:0] avg;

    seq_avg_next #(.NCH(NCH), .IDX_W(IDX_W)) i_next_cur (
        .mask(chan_mask), .base(st_q.cur), .nxt(skip_cur)
    );

    seq_avg_next #(.NCH(NCH), .IDX_W(IDX_W)) i_next_eff (
        .mask(chan_mask), .base(eff), .nxt(after_eff)
    );

    seq_avg_accum #(.SMP_W(SMP_W), .RES_W(RES_W), .OSR_W(OSR_W)) i_accum (
        .clk(clk), .rst_n(rst_n), .clr(!run), .take(take),
        .smp(smp_data), .osr(osr_sel), .done(done), .avg(avg)
    );

    seq_avg_stats #(.NCH(NCH), .RES_W(RES_W), .IDX_W(IDX_W)) i_stats (
        .clk(clk), .rst_n(rst_n), .wr(done), .wr_ch(eff), .wr_val(avg),
        .stat_en(stat_ctrl[STATS_BIT]),
        .rec_all(recent_all), .max_all(max_all), .min_all(min_all)
    );

    always_comb begin
        run  = seq_ctrl[SEQ_MODE_BIT] && seq_ctrl[SEQ_START_BIT]
            && mode_ctrl[AUTO_BIT] && (|chan_mask);
        take = run && smp_valid;
        eff  = chan_mask[st_q.cur] ? st_q.cur : skip_cur;

        st_d     = st_q;
        st_d.vld = done;
        if (done) begin
            st_d.cur = after_eff;
            st_d.ch  = eff;
            st_d.val = avg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chan_req  = run;
    assign chan_sel  = eff;
    assign res_valid = st_q.vld;
    assign res_chan  = st_q.ch;
    assign res_value = st_q.val;
endmodule

// File: rtl/chan_seq_averager_chk.sv
module chan_seq_averager_chk
    import seq_avg_pkg::*;
#(
    parameter  int unsigned NCH   = DEF_NCH,
    parameter  int unsigned SMP_W = DEF_SMP_W,
    parameter  int unsigned RES_W = DEF_RES_W,
    parameter  int unsigned OSR_W = DEF_OSR_W,
    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CFG_W-1:0]     seq_ctrl,
    input logic [CFG_W-1:0]     mode_ctrl,
    input logic [CFG_W-1:0]     stat_ctrl,
    input logic [OSR_W-1:0]     osr_sel,
    input logic [NCH-1:0]       chan_mask,
    input logic                 smp_valid,
    input logic [SMP_W-1:0]     smp_data,
    input logic                 chan_req,
    input logic [IDX_W-1:0]     chan_sel,
    input logic                 res_valid,
    input logic [IDX_W-1:0]     res_chan,
    input logic [RES_W-1:0]     res_value,
    input logic [NCH*RES_W-1:0] recent_all,
    input logic [NCH*RES_W-1:0] max_all,
    input logic [NCH*RES_W-1:0] min_all
);
    a_r2_result_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(chan_req && smp_valid));

    a_r3_result_channel: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_chan == $past(chan_sel)));

    a_r4_recent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(recent_all));

    a_r4_value_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (recent_all[res_chan*RES_W +: RES_W] == res_value));

    a_r5_sel_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        chan_req |-> chan_mask[chan_sel]);

    a_r6_stats_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_ctrl[STATS_BIT] |=> ($stable(max_all) && $stable(min_all)));

    a_r7_zero_mask_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_mask == '0) |-> !chan_req);
endmodule

bind chan_seq_averager chan_seq_averager_chk #(
    .NCH(NCH), .SMP_W(SMP_W), .RES_W(RES_W), .OSR_W(OSR_W)
) i_chk (.*);

// File: tb/test_chan_seq_averager.sv
module test_chan_seq_averager;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   seq_ctrl = '0, mode_ctrl = '0, stat_ctrl = '0;
    logic [2:0]   osr_sel = '0;
    logic [7:0]   chan_mask = '0;
    logic         smp_valid = 1'b0;
    logic [11:0]  smp_data = '0;
    logic         chan_req, res_valid;
    logic [2:0]   chan_sel, res_chan;
    logic [15:0]  res_value;
    logic [127:0] recent_all, max_all, min_all;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [15:0] m_rec [8];
    logic [15:0] m_max [8];
    logic [15:0] m_min [8];

    always #10 clk = ~clk;

    chan_seq_averager i_chan_seq_averager (.*);

    typedef struct packed {
        logic [2:0]  k;
        logic [11:0] a;
        logic [11:0] b;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{k: 3'd0, a: 12'hABC, b: 12'h000},
        '{k: 3'd1, a: 12'h100, b: 12'h300},
        '{k: 3'd2, a: 12'hFFF, b: 12'hFFF},
        '{k: 3'd3, a: 12'h001, b: 12'h002},
        '{k: 3'd7, a: 12'h800, b: 12'h7FF}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pack(input logic [15:0] v [8]);
        logic [127:0] r;
        for (int c = 0; c < 8; c++) r[c*16 +: 16] = v[c];
        return r;
    endfunction

    task automatic push(input logic [11:0] d);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = d;
    endtask

    task automatic idle();
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic check_model(input string req);
        check(req, recent_all, pack(m_rec));
        check(req, max_all, pack(m_max));
        check(req, min_all, pack(m_min));
    endtask

    // one averaged result on the currently selected channel
    task automatic run_avg(input logic [2:0] k, input logic [11:0] a, input logic [11:0] b);
        longint sum = 0;
        logic [15:0] e;
        logic [2:0] ch;
        osr_sel = k;
        ch = chan_sel;
        for (int i = 0; i < (1 << k); i++) begin
            push((i % 2) ? b : a);
            sum += longint'((i % 2) ? b : a) * 16;
        end
        idle();
        e = 16'(sum >> k);
        check("R3 strobe", 128'(res_valid), 128'(1));
        check("R3 value", 128'(res_value), 128'(e));
        check("R4 channel", 128'(res_chan), 128'(ch));
        m_rec[ch] = e;
        if (stat_ctrl[5]) begin
            if (e > m_max[ch]) m_max[ch] = e;
            if (e < m_min[ch]) m_min[ch] = e;
        end
        check_model("R4 R6 slots");
        idle();
        check("R3 single pulse", 128'(res_valid), 128'(0));
    endtask

    initial begin
        for (int c = 0; c < 8; c++) begin
            m_rec[c] = 16'h0000; m_max[c] = 16'h0000; m_min[c] = 16'hFFFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobe", 128'(res_valid), 128'(0));
        check_model("R1 reset slots");
        check("R2 idle request", 128'(chan_req), 128'(0));

        // table walk on channel 0
        seq_ctrl = 8'h11; mode_ctrl = 8'h20; stat_ctrl = 8'h20; chan_mask = 8'h01;
        @(negedge clk);
        check("R2 request on", 128'(chan_req), 128'(1));
        for (int v = 0; v < 5; v++) begin
            run_avg(VECS[v].k, VECS[v].a, VECS[v].b);
            check("R8 stays on ch0", 128'(chan_sel), 128'(0));
        end

        // round robin over 0,3,5
        chan_mask = 8'h29;
        #1;
        check("R5 start ch0", 128'(chan_sel), 128'(0));
        run_avg(3'd0, 12'h050, 12'h0);
        check("R5 next ch3", 128'(chan_sel), 128'(3));
        run_avg(3'd0, 12'hFFE, 12'h0);
        check("R5 next ch5", 128'(chan_sel), 128'(5));
        run_avg(3'd1, 12'h200, 12'h400);
        check("R5 wrap ch0", 128'(chan_sel), 128'(0));

        // disabling the pointed channel jumps at once
        chan_mask = 8'h20;
        #1;
        check("R5 skip to ch5", 128'(chan_sel), 128'(5));

        // statistics off
        stat_ctrl = 8'h00;
        run_avg(3'd0, 12'hFFF, 12'h0);
        run_avg(3'd0, 12'h001, 12'h0);
        check("R8 stays on ch5", 128'(chan_sel), 128'(5));
        stat_ctrl = 8'h20;

        // gating: start bit off, then autonomous bit off
        seq_ctrl = 8'h01;
        #1;
        check("R2 start off", 128'(chan_req), 128'(0));
        push(12'h777); idle();
        check("R2 ignored strobe", 128'(res_valid), 128'(0));
        check_model("R2 ignored slots");
        seq_ctrl = 8'h11; mode_ctrl = 8'h00;
        #1;
        check("R2 manual mode", 128'(chan_req), 128'(0));
        push(12'h777); idle();
        check("R2 manual ignored", 128'(res_valid), 128'(0));
        check_model("R2 manual slots");
        mode_ctrl = 8'h20;

        // zero mask halts
        chan_mask = 8'h00;
        #1;
        check("R7 halted", 128'(chan_req), 128'(0));
        push(12'h123); idle();
        check("R7 no strobe", 128'(res_valid), 128'(0));
        check_model("R7 slots");

        // resume on channel 7, new minimum and maximum
        chan_mask = 8'h80;
        #1;
        check("R5 resume ch7", 128'(chan_sel), 128'(7));
        run_avg(3'd2, 12'h400, 12'h600);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule